// File: doc/BRIEF.md
# Overlay-Window Command Issue Sequencer

This engine sits on the host side of a phase-change memory that exposes its command registers inside a memory-mapped overlay window. A client hands it one command at a time: a 16-bit operation code, a 32-bit data word, a 32-bit target address and a 32-bit count value. The engine then runs the whole issue sequence on a simple byte-addressed memory bus, one transaction at a time. It writes the command registers in a fixed order and, for the two buffered operations, reads the program-buffer pointer and streams the buffer words. It then writes the execute register and polls the status register until the ready bit appears or a poll budget runs out.

Two device arrangements are supported, selected per command by `pair_mode`. With a single 16-bit device, register offsets are scaled by two bytes. With two 16-bit devices side by side, offsets are scaled by four bytes and every register write and status read is repeated two bytes higher for the second device. The second device receives the upper half of the data word, and completion requires both devices to report ready.

Top module: `ow_cmd_seq`

## Requirements
- R1: While reset is low, and in idle after reset, `mem_req`, `req_ack`, `buf_ready`, `done` and `done_err` are all 0.
- R2: `req_ack` is 1 only in a cycle where the engine is idle and `req_valid` is 1. A request raised while a command is in progress is not acknowledged and does not alter the command under way.
- R3: A supported command starts with six writes, in this order, to word offsets 0x40 (operation code), 0x42 (data low half), 0x44 (address bits 15:0), 0x45 (address bits 31:16), 0x48 (count bits 15:0) and 0x49 (count bits 31:16). Each write carries a 16-bit value at byte address BASE + offset × 2 in single mode.
- R4: In paired mode the offsets are scaled by 4. After the six writes for the first device, the same six writes are repeated at +2 bytes, with data bits 31:16 in place of the low half.
- R5: Only operation codes 0xE9 and 0xEA fill the buffer. For these, the register writes are followed by a read of word offset 0x08, whose low 16 bits are the pointer P. Then `count` buffer words are written to BASE + P + i, for i = 0 .. count-1, taking each word from `buf_data` when `buf_valid` is 1. A count of 0 writes no buffer words.
- R6: After the register writes (and any buffer fill), value 0x0001 is written to word offset 0x60, and in paired mode repeated at +2.
- R7: The engine then reads word offset 0x66 (in paired mode both devices, first then second) in rounds. It finishes with `done` = 1 and `done_err` = 0 after the first round in which bit 7 is set on every device read.
- R8: If `poll_limit` rounds complete without ready, the engine finishes with `done_err` = 1 after the last round and issues no further reads. A limit of 0 acts as 1.
- R9: Only the codes 0x20, 0x41, 0x42, 0x61, 0x62, 0xE9 and 0xEA are supported. Any other code gives `done` = 1 with `done_err` = 1 on the cycle after acceptance, with no bus transaction.
- R10: A transaction with `mem_req` = 1 and `mem_wait` = 1 stays presented with unchanged address, direction and write data on the following cycle.
- R11: `done` is a one-cycle pulse, after which the engine is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_mode | input | 1 | 1 selects two stacked 16-bit devices, sampled when a command is accepted |
| poll_limit | input | POLL_W | Maximum number of status poll rounds |
| req_valid | input | 1 | Command request present |
| req_ack | output | 1 | Request accepted this cycle |
| req_code | input | 16 | Operation code |
| req_data | input | 32 | Data word for the command data register |
| req_addr | input | 32 | Target address, split into halves |
| req_count | input | 32 | Count value; also the number of buffer words |
| buf_valid | input | 1 | Buffer word available |
| buf_ready | output | 1 | Buffer word consumed this cycle |
| buf_data | input | 16 | Buffer word |
| mem_req | output | 1 | Bus transaction presented |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_wait | input | 1 | Target stalls the presented transaction |
| mem_rdata | input | 16 | Read data, valid in the cycle a read completes |
| done | output | 1 | Command finished (one-cycle pulse) |
| done_err | output | 1 | Finished with error, valid with `done` |

## Verification
The hold property assumes that once `buf_valid` is raised during the buffer fill, it stays high with stable `buf_data` until `buf_ready` takes the word. The bench's word source only changes `buf_valid` or `buf_data` right after a consumption or while idle. The properties also assume that `poll_limit` does not change while a command runs, so the bench sets it only between commands. `mem_wait` may stall any transaction for any number of cycles, and the bench drives it from a pseudo-random sequence.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

    localparam int HALF_W    = 16;
    localparam int REG_SLOTS = 6;
    localparam int READY_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REGS = 3'd1,
        ST_PTR  = 3'd2,
        ST_FILL = 3'd3,
        ST_EXEC = 3'd4,
        ST_POLL = 3'd5,
        ST_DONE = 3'd6
    } seq_state_e;

    // overlay word offsets
    localparam logic [7:0] OFS_CODE    = 8'h40;
    localparam logic [7:0] OFS_DATA    = 8'h42;
    localparam logic [7:0] OFS_ADDR_LO = 8'h44;
    localparam logic [7:0] OFS_ADDR_HI = 8'h45;
    localparam logic [7:0] OFS_CNT_LO  = 8'h48;
    localparam logic [7:0] OFS_CNT_HI  = 8'h49;
    localparam logic [7:0] OFS_BUFPTR  = 8'h08;
    localparam logic [7:0] OFS_EXEC    = 8'h60;
    localparam logic [7:0] OFS_STATUS  = 8'h66;

    // operation codes
    localparam logic [15:0] OP_ERASE   = 16'h0020;
    localparam logic [15:0] OP_WPROG   = 16'h0041;
    localparam logic [15:0] OP_WOVER   = 16'h0042;
    localparam logic [15:0] OP_LOCK    = 16'h0061;
    localparam logic [15:0] OP_UNLOCK  = 16'h0062;
    localparam logic [15:0] OP_BPROG   = 16'h00E9;
    localparam logic [15:0] OP_BOVER   = 16'h00EA;

    localparam logic [15:0] EXEC_GO    = 16'h0001;

    function automatic logic op_buffered(input logic [15:0] c);
        return (c == OP_BPROG) || (c == OP_BOVER);
    endfunction

    function automatic logic op_known(input logic [15:0] c);
        return op_buffered(c) || (c == OP_ERASE) || (c == OP_WPROG) ||
               (c == OP_WOVER) || (c == OP_LOCK) || (c == OP_UNLOCK);
    endfunction

    // register slot sequence position -> overlay offset
    function automatic logic [7:0] slot_offset(input logic [2:0] s);
        case (s)
            3'd0:    return OFS_CODE;
            3'd1:    return OFS_DATA;
            3'd2:    return OFS_ADDR_LO;
            3'd3:    return OFS_ADDR_HI;
            3'd4:    return OFS_CNT_LO;
            default: return OFS_CNT_HI;
        endcase
    endfunction

endpackage

// File: rtl/ow_bus_map.sv
module ow_bus_map
    import owseq_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  seq_state_e          state,
    input  logic [2:0]          slot,
    input  logic                dev,
    input  logic                pair,
    input  logic [15:0]         code,
    input  logic [31:0]         data,
    input  logic [31:0]         addr,
    input  logic [31:0]         count,
    input  logic [HALF_W-1:0]   ptr,
    input  logic [31:0]         fill_idx,
    input  logic [HALF_W-1:0]   fill_word,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [HALF_W-1:0]   bus_wdata,
    output logic                bus_we
);

    // overlay register byte address for a device lane
    function automatic logic [ADDR_W-1:0] reg_at(input logic [7:0] ofs,
                                                 input logic two_dev,
                                                 input logic hi_dev);
        logic [ADDR_W-1:0] scaled;
        scaled = two_dev ? ADDR_W'({ofs, 2'b00}) : ADDR_W'({ofs, 1'b0});
        return BASE_ADDR + scaled + (hi_dev ? ADDR_W'(2) : '0);
    endfunction

    logic [HALF_W-1:0] slot_value;

    always_comb begin
        case (slot)
            3'd0:    slot_value = code;
            3'd1:    slot_value = dev ? data[31:16] : data[15:0];
            3'd2:    slot_value = addr[15:0];
            3'd3:    slot_value = addr[31:16];
            3'd4:    slot_value = count[15:0];
            default: slot_value = count[31:16];
        endcase
    end

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        case (state)
            ST_REGS: begin
                bus_addr  = reg_at(slot_offset(slot), pair, dev);
                bus_wdata = slot_value;
                bus_we    = 1'b1;
            end
            ST_PTR: begin
                bus_addr  = reg_at(OFS_BUFPTR, pair, 1'b0);
            end
            ST_FILL: begin
                bus_addr  = BASE_ADDR + ADDR_W'(ptr) + ADDR_W'(fill_idx);
                bus_wdata = fill_word;
                bus_we    = 1'b1;
            end
            ST_EXEC: begin
                bus_addr  = reg_at(OFS_EXEC, pair, dev);
                bus_wdata = EXEC_GO;
                bus_we    = 1'b1;
            end
            ST_POLL: begin
                bus_addr  = reg_at(OFS_STATUS, pair, dev);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ow_poll_judge.sv
module ow_poll_judge
    import owseq_pkg::*;
#(
    parameter int POLL_W = 16
) (
    input  logic              pair,
    input  logic              lo_rdy,
    input  logic              now_rdy,
    input  logic [POLL_W-1:0] fails,
    input  logic [POLL_W-1:0] limit,
    output logic              ready,
    output logic              give_up
);

    localparam int LANES = 2;

    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] lane_used;
    logic [POLL_W:0]  rounds_done;

    // lane 0 is the first device (or the only one), lane 1 the second
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_ok[g]   = pair ? lo_rdy : now_rdy;
            assign lane_used[g] = 1'b1;
        end else begin : g_second
            assign lane_ok[g]   = now_rdy;
            assign lane_used[g] = pair;
        end
    end

    assign ready       = &(lane_ok | ~lane_used);
    assign rounds_done = {1'b0, fails} + 1'b1;
    assign give_up     = !ready && (rounds_done >= {1'b0, limit});

endmodule

// File: rtl/ow_cmd_seq.sv
module ow_cmd_seq
    import owseq_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                POLL_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_mode,
    input  logic [POLL_W-1:0]   poll_limit,
    input  logic                req_valid,
    output logic                req_ack,
    input  logic [15:0]         req_code,
    input  logic [31:0]         req_data,
    input  logic [31:0]         req_addr,
    input  logic [31:0]         req_count,
    input  logic                buf_valid,
    output logic                buf_ready,
    input  logic [HALF_W-1:0]   buf_data,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [HALF_W-1:0]   mem_wdata,
    input  logic                mem_wait,
    input  logic [HALF_W-1:0]   mem_rdata,
    output logic                done,
    output logic                done_err
);

    localparam logic [2:0] LAST_SLOT = 3'(REG_SLOTS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [2:0]         slot;
        logic               dev;
        logic               pair;
        logic [15:0]        code;
        logic [31:0]        data;
        logic [31:0]        addr;
        logic [31:0]        count;
        logic [HALF_W-1:0]  ptr;
        logic [31:0]        fill_n;
        logic               lo_rdy;
        logic [POLL_W-1:0]  fails;
        logic               err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic xfer;
    logic rdy_now;
    logic stop_now;
    logic last_lane;

    ow_bus_map #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_map (
        .state     (ctx_q.st),
        .slot      (ctx_q.slot),
        .dev       (ctx_q.dev),
        .pair      (ctx_q.pair),
        .code      (ctx_q.code),
        .data      (ctx_q.data),
        .addr      (ctx_q.addr),
        .count     (ctx_q.count),
        .ptr       (ctx_q.ptr),
        .fill_idx  (ctx_q.fill_n),
        .fill_word (buf_data),
        .bus_addr  (mem_addr),
        .bus_wdata (mem_wdata),
        .bus_we    (mem_we)
    );

    ow_poll_judge #(
        .POLL_W (POLL_W)
    ) u_judge (
        .pair    (ctx_q.pair),
        .lo_rdy  (ctx_q.lo_rdy),
        .now_rdy (mem_rdata[READY_BIT]),
        .fails   (ctx_q.fails),
        .limit   (poll_limit),
        .ready   (rdy_now),
        .give_up (stop_now)
    );

    assign mem_req = (ctx_q.st == ST_REGS) || (ctx_q.st == ST_PTR) ||
                     (ctx_q.st == ST_EXEC) || (ctx_q.st == ST_POLL) ||
                     ((ctx_q.st == ST_FILL) && buf_valid);
    assign xfer      = mem_req && !mem_wait;
    assign last_lane = !ctx_q.pair || ctx_q.dev;
    assign done      = (ctx_q.st == ST_DONE);
    assign done_err  = done && ctx_q.err;

    always_comb begin
        ctx_d     = ctx_q;
        req_ack   = 1'b0;
        buf_ready = 1'b0;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    req_ack      = 1'b1;
                    ctx_d.code   = req_code;
                    ctx_d.data   = req_data;
                    ctx_d.addr   = req_addr;
                    ctx_d.count  = req_count;
                    ctx_d.pair   = pair_mode;
                    ctx_d.slot   = '0;
                    ctx_d.dev    = 1'b0;
                    ctx_d.fill_n = '0;
                    ctx_d.fails  = '0;
                    ctx_d.err    = !op_known(req_code);
                    ctx_d.st     = op_known(req_code) ? ST_REGS : ST_DONE;
                end
            end
            ST_REGS: begin
                if (xfer) begin
                    if (ctx_q.slot == LAST_SLOT) begin
                        ctx_d.slot = '0;
                        if (!last_lane) begin
                            ctx_d.dev = 1'b1;
                        end else begin
                            ctx_d.dev = 1'b0;
                            ctx_d.st  = op_buffered(ctx_q.code) ? ST_PTR : ST_EXEC;
                        end
                    end else begin
                        ctx_d.slot = ctx_q.slot + 3'd1;
                    end
                end
            end
            ST_PTR: begin
                if (xfer) begin
                    ctx_d.ptr    = mem_rdata;
                    ctx_d.fill_n = '0;
                    ctx_d.st     = (ctx_q.count == '0) ? ST_EXEC : ST_FILL;
                end
            end
            ST_FILL: begin
                buf_ready = xfer;
                if (xfer) begin
                    ctx_d.fill_n = ctx_q.fill_n + 32'd1;
                    if (ctx_q.fill_n + 32'd1 == ctx_q.count) begin
                        ctx_d.st = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                if (xfer) begin
                    if (!last_lane) begin
                        ctx_d.dev = 1'b1;
                    end else begin
                        ctx_d.dev   = 1'b0;
                        ctx_d.fails = '0;
                        ctx_d.st    = ST_POLL;
                    end
                end
            end
            ST_POLL: begin
                if (xfer) begin
                    if (!last_lane) begin
                        ctx_d.lo_rdy = mem_rdata[READY_BIT];
                        ctx_d.dev    = 1'b1;
                    end else begin
                        ctx_d.dev = 1'b0;
                        if (rdy_now) begin
                            ctx_d.st = ST_DONE;
                        end else if (stop_now) begin
                            ctx_d.st  = ST_DONE;
                            ctx_d.err = 1'b1;
                        end else begin
                            ctx_d.fails = ctx_q.fails + 1'b1;
                        end
                    end
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_IDLE) |-> !mem_req && !buf_ready);  // R1

    AST_ACK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);  // R2

    AST_EXEC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ctx_q.st == ST_EXEC) |-> mem_we && (mem_wdata == EXEC_GO));  // R6

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_err) |-> $past(mem_req && !mem_wait && !mem_we));  // R7

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && !op_known(req_code)) |=> done && done_err && !mem_req);  // R9

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wait) |=> mem_req && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_wdata));  // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !mem_req);  // R11

endmodule

// File: tb/ow_cmd_seq_test.sv
module ow_cmd_seq_test;

    localparam int          AW   = 32;
    localparam int          PW   = 16;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           pair_mode = 1'b0;
    logic [PW-1:0]  poll_limit = 16'd8;
    logic           req_valid = 1'b0;
    logic           req_ack;
    logic [15:0]    req_code = '0;
    logic [31:0]    req_data = '0;
    logic [31:0]    req_addr = '0;
    logic [31:0]    req_count = '0;
    logic           buf_valid = 1'b0;
    logic           buf_ready;
    logic [15:0]    buf_data = '0;
    logic           mem_req;
    logic           mem_we;
    logic [AW-1:0]  mem_addr;
    logic [15:0]    mem_wdata;
    logic           mem_wait = 1'b0;
    logic [15:0]    mem_rdata;
    logic           done;
    logic           done_err;

    ow_cmd_seq #(.ADDR_W(AW), .POLL_W(PW), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode), .poll_limit(poll_limit),
        .req_valid(req_valid), .req_ack(req_ack), .req_code(req_code),
        .req_data(req_data), .req_addr(req_addr), .req_count(req_count),
        .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_data(buf_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
        .done(done), .done_err(done_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference model state: expected bus transactions and buffer words
    typedef struct {
        bit          we;
        logic [31:0] a;
        logic [15:0] d;
        string       tag;
    } xact_t;

    xact_t       expq[$];
    logic [15:0] fillq[$];

    bit          cur_pair = 1'b0;
    logic [15:0] ptr_val  = '0;
    int          sreads[2];
    int          rdy_abs[2];
    logic [15:0] lfsr = 16'hACE1;
    bit          wait_en = 1'b0;

    initial begin
        sreads[0] = 0; sreads[1] = 0; rdy_abs[0] = 0; rdy_abs[1] = 0;
    end

    function automatic logic [31:0] oaddr(input int off, input int dev);
        return BASE + 32'(off * (cur_pair ? 4 : 2) + 2 * dev);
    endfunction

    function automatic logic [15:0] resp(input logic [31:0] a);
        if (a == oaddr(8'h08, 0)) return ptr_val;
        for (int d = 0; d < 2; d++) begin
            if (a == oaddr(8'h66, d)) return (sreads[d] >= rdy_abs[d]) ? 16'h0180 : 16'h0100;
        end
        return 16'hBEEF;
    endfunction

    always_comb mem_rdata = resp(mem_addr);

    // memory responder and buffer-word source, updated after each edge
    always @(posedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_wait <= wait_en && lfsr[0] && lfsr[3];
        if (mem_req && !mem_wait && !mem_we) begin
            for (int d = 0; d < 2; d++) begin
                if (mem_addr == oaddr(8'h66, d)) sreads[d] <= sreads[d] + 1;
            end
        end
        if (buf_ready && fillq.size() > 0) void'(fillq.pop_front());
        if (buf_ready || !buf_valid) begin
            buf_valid <= (fillq.size() > 0) && !lfsr[1];
            buf_data  <= (fillq.size() > 0) ? fillq[0] : 16'h0;
        end
    end

    // per-cycle comparison against the expected transaction stream
    bit          prev_hold = 1'b0;
    logic [31:0] prev_a;
    logic        prev_we;
    logic [15:0] prev_d;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold)
                check(mem_req && mem_addr == prev_a && mem_we == prev_we && mem_wdata == prev_d,
                      "R10", "stalled transaction changed",
                      {mem_req, mem_we, mem_addr, mem_wdata}, {1'b1, prev_we, prev_a, prev_d});
            prev_hold = mem_req && mem_wait;
            prev_a    = mem_addr;
            prev_we   = mem_we;
            prev_d    = mem_wdata;
            if (mem_req && !mem_wait) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R3", "unexpected bus access", {mem_we, mem_addr, mem_wdata}, 64'h0);
                end else begin
                    xact_t x;
                    x = expq.pop_front();
                    check(mem_we == x.we && mem_addr == x.a && (!x.we || mem_wdata == x.d),
                          x.tag, "bus access",
                          {mem_we, mem_addr, mem_wdata}, {x.we, x.a, x.d});
                end
            end
        end
    end

    task automatic push(input bit we, input logic [31:0] a, input logic [15:0] d, input string tag);
        xact_t x;
        x.we = we; x.a = a; x.d = d; x.tag = tag;
        expq.push_back(x);
    endtask

    task automatic run_cmd(input logic [15:0] code, input logic [31:0] data,
                           input logic [31:0] addr, input logic [31:0] count,
                           input bit pair, input int limit, input int r0, input int r1,
                           input logic [15:0] ptr, input bit poke, input string tag);
        bit known, buffered, exp_err;
        int need, lim, rounds, n;
        logic [15:0] vals[6];
        int offs[6];
        known    = code inside {16'h20, 16'h41, 16'h42, 16'h61, 16'h62, 16'hE9, 16'hEA};
        buffered = (code == 16'hE9) || (code == 16'hEA);
        cur_pair   = pair;
        pair_mode  = pair;
        poll_limit = PW'(limit);
        ptr_val    = ptr;
        rdy_abs[0] = sreads[0] + r0;
        rdy_abs[1] = sreads[1] + r1;
        exp_err    = 1'b1;
        if (known) begin
            offs = '{8'h40, 8'h42, 8'h44, 8'h45, 8'h48, 8'h49};
            for (int dv = 0; dv <= int'(pair); dv++) begin
                vals = '{code, (dv == 1) ? data[31:16] : data[15:0], addr[15:0], addr[31:16],
                         count[15:0], count[31:16]};
                for (int s = 0; s < 6; s++) push(1'b1, oaddr(offs[s], dv), vals[s], dv == 1 ? "R4" : "R3");
            end
            if (buffered) begin
                push(1'b0, oaddr(8'h08, 0), 16'h0, "R5");
                for (int i = 0; i < int'(count); i++) begin
                    logic [15:0] w;
                    w = 16'h5A00 + 16'(i * 7) + code;
                    fillq.push_back(w);
                    push(1'b1, BASE + 32'(ptr) + 32'(i), w, "R5");
                end
            end
            for (int dv = 0; dv <= int'(pair); dv++) push(1'b1, oaddr(8'h60, dv), 16'h0001, "R6");
            need    = ((r0 > r1 || !pair) ? r0 : r1) + 1;
            lim     = (limit == 0) ? 1 : limit;
            rounds  = (need < lim) ? need : lim;
            exp_err = need > lim;
            for (int r = 0; r < rounds; r++)
                for (int dv = 0; dv <= int'(pair); dv++)
                    push(1'b0, oaddr(8'h66, dv), 16'h0, exp_err ? "R8" : "R7");
        end
        @(negedge clk);
        req_code = code; req_data = data; req_addr = addr; req_count = count;
        req_valid = 1'b1;
        #1 check(req_ack == 1'b1, "R2", "acknowledge while idle", req_ack, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_code  = 16'h0020;
            #1 check(req_ack == 1'b0, "R2", "acknowledge while busy", req_ack, 0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(n < 4000, tag, "command never finished", n, 4000);
        check(done_err == exp_err, tag, "completion error flag", done_err, exp_err);
        check(expq.size() == 0, tag, "transactions missing", expq.size(), 0);
        check(fillq.size() == 0, "R5", "buffer words not consumed", fillq.size(), 0);
        expq.delete();
        fillq.delete();
        @(negedge clk);
        check(!done && !mem_req, "R11", "done pulse length", {done, mem_req}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req && !req_ack && !buf_ready && !done && !done_err, "R1", "outputs in reset",
              {mem_req, req_ack, buf_ready, done, done_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !req_ack && !buf_ready && !done, "R1", "outputs idle after reset",
              {mem_req, req_ack, buf_ready, done}, 0);

        // single-word program, one device, ready at once
        run_cmd(16'h0041, 32'h1234_ABCD, 32'h0012_3456, 32'h0, 1'b0, 8, 0, 0, 16'h0, 1'b1, "R7");
        // erase, two devices, ready after two rounds
        wait_en = 1'b1;
        run_cmd(16'h0020, 32'h0, 32'h0002_0000, 32'h0002_0000, 1'b1, 8, 2, 2, 16'h0, 1'b1, "R4");
        // buffer program, one device
        run_cmd(16'h00E9, 32'h0, 32'h0000_0400, 32'd5, 1'b0, 8, 1, 0, 16'h0010, 1'b0, "R5");
        // buffer overwrite, two devices
        run_cmd(16'h00EA, 32'hFFFF_0000, 32'h8000_0800, 32'd3, 1'b1, 8, 0, 1, 16'h0020, 1'b1, "R5");
        // buffered command with zero count
        run_cmd(16'h00E9, 32'h0, 32'h0000_1000, 32'd0, 1'b0, 8, 0, 0, 16'h0030, 1'b0, "R5");
        // poll budget exhausted
        run_cmd(16'h0061, 32'h0, 32'h0004_0000, 32'h0004_0000, 1'b0, 3, 10, 0, 16'h0, 1'b0, "R8");
        // limit of zero behaves as one round
        run_cmd(16'h0062, 32'h0, 32'h0006_0000, 32'h0, 1'b1, 0, 5, 5, 16'h0, 1'b0, "R8");
        // second device late: both halves of the mask required
        run_cmd(16'h0042, 32'hCAFE_BABE, 32'hDEAD_BEEF, 32'h0, 1'b1, 8, 0, 3, 16'h0, 1'b1, "R7");
        // second device never ready within budget
        run_cmd(16'h0041, 32'h0000_5555, 32'h0000_0002, 32'h0, 1'b1, 2, 0, 9, 16'h0, 1'b0, "R8");
        // unsupported codes
        run_cmd(16'h0033, 32'h0, 32'h0, 32'h0, 1'b0, 8, 0, 0, 16'h0, 1'b0, "R9");
        run_cmd(16'h01E9, 32'h0, 32'h0, 32'd4, 1'b1, 8, 0, 0, 16'h0, 1'b0, "R9");
        // back-to-back after a rejection
        run_cmd(16'h00EA, 32'h0, 32'h0000_0010, 32'd2, 1'b0, 8, 0, 0, 16'h0002, 1'b0, "R5");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule